// File: doc/BRIEF.md
# Bus Cycle Sequencer

This block runs external memory and I/O transfers for a processor core whose lower address lines share pins with the data bus. The core raises a one-clock request carrying direction, space (memory or I/O), address, write data and size (byte or word). The sequencer then steps through clock states T1, T2, T3 and T4, one clock each. It drives the address latch strobe, the direction and data-enable controls, and the active-low read or write strobe in the proper states. When the synchronized ready input is low at the end of T3, it stretches the cycle with wait states.

The 16-bit bus is split into an even (low) byte lane and an odd (high) byte lane. An active-low high-bank enable, together with address bit 0, selects the lane or lanes in use. A word request at an odd address runs as two byte cycles back to back. The block holds the request fields from acceptance until the done pulse, so the core only needs to pulse `req_i`. Read data is returned on `rdata_o`, and it is valid while `done_o` is high.

Top module: `bus_cycle_seq`

## Requirements
- R1: While `rst_ni` is low and right after it is released, the outputs are quiet: `ale_o`=0, `rd_no`=`wr_no`=`den_no`=1, `ad_oe_o`=0, `bhe_no`=1 and `done_o`=0.
- R2: A request seen in idle at a rising edge puts T1 on the next clock. A cycle lasts 4+N clocks from T1 to T4 inclusive, where N is the number of wait states.
- R3: In T1, and only for that one clock, `ale_o` is 1. In T1 `ad_oe_o`=1, `ad_o` carries cycle address bits 15:0, `a_hi_o` carries the upper address bits, `mio_o` is 1 for memory and 0 for I/O, and `dtr_o` is 1 for a write and 0 for a read.
- R4: From T2 up to the last wait state, `den_no` is 0. For a read, `rd_no` is 0 and `ad_oe_o` is 0. For a write, `wr_no` is 0, `ad_oe_o` is 1 and the write data is on the active lane. `rd_no` and `wr_no` are never both 0.
- R5: `ready_i` passes through a two-stage synchronizer. Suppose `ready_i` has been low for at least two clocks before T1 and rises during clock D of the cycle, with T1 as clock 0. The cycle then holds exactly D wait states. If `ready_i` stays high, there are none.
- R6: In T4, `rd_no`, `wr_no` and `den_no` return to 1. Write data stays on `ad_o` with `ad_oe_o`=1 through T4, so the device latches it on the rising edge of `wr_no`. `done_o` is 1 for the final T4 only, for exactly one clock.
- R7: Read data is taken from `ad_i` at the end of the last T3 or wait state and shown on `rdata_o` while `done_o` is 1.
- R8: Lane selection by address bit 0 and `bhe_no`:
  - An even byte uses `bhe_no`=1 and the data sits on bits 7:0.
  - An odd byte uses `bhe_no`=0 and the data sits on bits 15:8.
  - An even word uses `bhe_no`=0 and all 16 bits.
  - A byte read returns the byte in `rdata_o[7:0]`, with bits 15:8 zero.
- R9: A word at an odd address A runs as two byte cycles. The first is at A on the high lane and carries data bits 7:0. The second is at A+1 on the low lane and carries data bits 15:8. The second T1 follows the first T4 directly, and `done_o` stays 0 until the second T4.
- R10: With no request, the block stays in idle with `ale_o`=0, both strobes at 1 and `ad_oe_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transfer request pulse from the core |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory |
| req_word_i | input | 1 | 1 = word, 0 = byte |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 16 | Write data (byte in bits 7:0) |
| done_o | output | 1 | Transfer complete pulse |
| rdata_o | output | 16 | Read data |
| ready_i | input | 1 | Asynchronous ready from the device |
| ad_i | input | 16 | Multiplexed bus, incoming |
| ad_o | output | 16 | Multiplexed bus, outgoing |
| ad_oe_o | output | 1 | Multiplexed bus output enable |
| a_hi_o | output | ADDR_W-16 | Upper address bits |
| ale_o | output | 1 | Address latch strobe |
| bhe_no | output | 1 | High byte lane enable, active low |
| mio_o | output | 1 | 1 = memory, 0 = I/O |
| dtr_o | output | 1 | Direction, 1 = transmit |
| den_no | output | 1 | Data buffer enable, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |

## Verification
A wrong state value shows up at the strobes within a clock. A skipped or repeated state changes the cycle length counted from `ale_o` to `done_o`. A wait state taken too soon or too late moves that length away from 4+D. A phase error in the odd-word split shows up at once in three ways: the wrong lane in `bhe_no`, the wrong address in the second T1, or an early `done_o`. A capture at the wrong moment corrupts `rdata_o` in the done clock. For writes, a lane or hold error corrupts the bench memory model and is caught by a direct compare after the cycle.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_TW,
    ST_T4
  } bus_state_e;
endpackage

// File: rtl/bseq_ready_sync.sv
module bseq_ready_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= {q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = q[STAGES-1];
endmodule

// File: rtl/bseq_lane_map.sv
module bseq_lane_map import bseq_pkg::*; #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_i,
  input  logic              phase_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [DATA_W-1:0] rdata_q_i,
  output logic              split_o,
  output logic [ADDR_W-1:0] cyc_addr_o,
  output logic              bhe_n_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic [DATA_W-1:0] rdata_nxt_o
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic              full_word;
  logic [BYTE_W-1:0] wbyte;
  logic [BYTE_W-1:0] lane_byte;

  assign split_o    = word_i & addr_i[0];
  assign full_word  = word_i & ~addr_i[0];
  assign cyc_addr_o = phase_i ? addr_i + ONE : addr_i;
  assign bhe_n_o    = ~(cyc_addr_o[0] | full_word);

  // second half of a split word carries the upper data byte
  assign wbyte       = (split_o & phase_i) ? wdata_i[DATA_W-1:BYTE_W] : wdata_i[BYTE_W-1:0];
  assign bus_wdata_o = full_word ? wdata_i : {wbyte, wbyte};
  assign lane_byte   = cyc_addr_o[0] ? ad_i[DATA_W-1:BYTE_W] : ad_i[BYTE_W-1:0];

  always_comb begin
    if (full_word)        rdata_nxt_o = ad_i;
    else if (!split_o)    rdata_nxt_o = {{BYTE_W{1'b0}}, lane_byte};
    else if (!phase_i)    rdata_nxt_o = {rdata_q_i[DATA_W-1:BYTE_W], lane_byte};
    else                  rdata_nxt_o = {lane_byte, rdata_q_i[BYTE_W-1:0]};
  end
endmodule

// File: rtl/bseq_cycle_ctrl.sv
module bseq_cycle_ctrl import bseq_pkg::*; #(
  parameter int unsigned ADDR_W = 20,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_write_i,
  input  logic              req_io_i,
  input  logic              req_word_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              rdy_i,
  // lane map interface
  input  logic              split_i,
  input  logic [ADDR_W-1:0] cyc_addr_i,
  input  logic              bhe_n_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [DATA_W-1:0] rdata_nxt_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              cur_word_o,
  output logic              phase_o,
  output logic [DATA_W-1:0] cur_wdata_o,
  output logic [DATA_W-1:0] rdata_q_o,
  // core and bus
  output logic              done_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [HI_W-1:0]   a_hi_o,
  output logic              ale_o,
  output logic              bhe_no,
  output logic              mio_o,
  output logic              dtr_o,
  output logic              den_no,
  output logic              rd_no,
  output logic              wr_no
);
  bus_state_e        state_q, state_d;
  logic              phase_q;
  logic              cur_write_q, cur_io_q, cur_word_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [DATA_W-1:0] cur_wdata_q, rdata_q;
  logic              busy, strobe_win, sample_win;

  assign busy       = (state_q != ST_IDLE);
  assign strobe_win = (state_q == ST_T2) || (state_q == ST_T3) || (state_q == ST_TW);
  assign sample_win = (state_q == ST_T3) || (state_q == ST_TW);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (req_i) state_d = ST_T1;
      ST_T1:        state_d = ST_T2;
      ST_T2:        state_d = ST_T3;
      ST_T3, ST_TW: state_d = rdy_i ? ST_T4 : ST_TW;
      ST_T4:        state_d = (split_i && !phase_q) ? ST_T1 : ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      phase_q     <= 1'b0;
      cur_write_q <= 1'b0;
      cur_io_q    <= 1'b0;
      cur_word_q  <= 1'b0;
      cur_addr_q  <= '0;
      cur_wdata_q <= '0;
      rdata_q     <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_i) begin
        cur_write_q <= req_write_i;
        cur_io_q    <= req_io_i;
        cur_word_q  <= req_word_i;
        cur_addr_q  <= req_addr_i;
        cur_wdata_q <= req_wdata_i;
        phase_q     <= 1'b0;
      end
      if (state_q == ST_T4) phase_q <= split_i && !phase_q;
      if (sample_win && rdy_i && !cur_write_q) rdata_q <= rdata_nxt_i;
    end
  end

  assign cur_addr_o  = cur_addr_q;
  assign cur_word_o  = cur_word_q;
  assign phase_o     = phase_q;
  assign cur_wdata_o = cur_wdata_q;
  assign rdata_q_o   = rdata_q;

  assign ale_o   = (state_q == ST_T1);
  assign ad_o    = (state_q == ST_T1) ? cyc_addr_i[DATA_W-1:0] : bus_wdata_i;
  assign ad_oe_o = (state_q == ST_T1) || (busy && cur_write_q);  // write data held into T4
  assign a_hi_o  = busy ? cyc_addr_i[ADDR_W-1:DATA_W] : '0;
  assign bhe_no  = busy ? bhe_n_i : 1'b1;
  assign mio_o   = busy && !cur_io_q;
  assign dtr_o   = busy && cur_write_q;
  assign den_no  = !strobe_win;
  assign rd_no   = !(strobe_win && !cur_write_q);
  assign wr_no   = !(strobe_win && cur_write_q);
  assign done_o  = (state_q == ST_T4) && (!split_i || phase_q);

  AST_ALE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);  // R3
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));  // R4
  AST_READ_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ad_oe_o);  // R4
  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_win && !rdy_i) |=> (state_q == ST_TW) && !den_no);  // R5
  AST_READY_ENDS_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_win && rdy_i) |=> den_no && rd_no && wr_no);  // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R6
  AST_SPLIT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_T4 && !done_o) |=> ale_o);  // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (rd_no && wr_no && !ale_o && !ad_oe_o));  // R10
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq import bseq_pkg::*; #(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned HI_W       = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_write_i,
  input  logic              req_io_i,
  input  logic              req_word_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [HI_W-1:0]   a_hi_o,
  output logic              ale_o,
  output logic              bhe_no,
  output logic              mio_o,
  output logic              dtr_o,
  output logic              den_no,
  output logic              rd_no,
  output logic              wr_no
);
  logic              rdy_s;
  logic              split, bhe_n, cur_word, phase;
  logic [ADDR_W-1:0] cyc_addr, cur_addr;
  logic [DATA_W-1:0] bus_wdata, rdata_nxt, cur_wdata, rdata_q;

  bseq_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ready_i),
    .sync_o  (rdy_s)
  );

  bseq_lane_map #(.ADDR_W(ADDR_W)) u_lane (
    .addr_i      (cur_addr),
    .word_i      (cur_word),
    .phase_i     (phase),
    .wdata_i     (cur_wdata),
    .ad_i        (ad_i),
    .rdata_q_i   (rdata_q),
    .split_o     (split),
    .cyc_addr_o  (cyc_addr),
    .bhe_n_o     (bhe_n),
    .bus_wdata_o (bus_wdata),
    .rdata_nxt_o (rdata_nxt)
  );

  bseq_cycle_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .req_write_i (req_write_i),
    .req_io_i    (req_io_i),
    .req_word_i  (req_word_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .rdy_i       (rdy_s),
    .split_i     (split),
    .cyc_addr_i  (cyc_addr),
    .bhe_n_i     (bhe_n),
    .bus_wdata_i (bus_wdata),
    .rdata_nxt_i (rdata_nxt),
    .cur_addr_o  (cur_addr),
    .cur_word_o  (cur_word),
    .phase_o     (phase),
    .cur_wdata_o (cur_wdata),
    .rdata_q_o   (rdata_q),
    .done_o      (done_o),
    .ad_o        (ad_o),
    .ad_oe_o     (ad_oe_o),
    .a_hi_o      (a_hi_o),
    .ale_o       (ale_o),
    .bhe_no      (bhe_no),
    .mio_o       (mio_o),
    .dtr_o       (dtr_o),
    .den_no      (den_no),
    .rd_no       (rd_no),
    .wr_no       (wr_no)
  );

  assign rdata_o = rdata_q;
endmodule

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;
  localparam int AW = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, req_write_i = 1'b0, req_io_i = 1'b0, req_word_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [15:0]   req_wdata_i = '0;
  logic          ready_i = 1'b1;
  logic [15:0]   ad_i, ad_o, rdata_o;
  logic [3:0]    a_hi_o;
  logic          done_o, ad_oe_o, ale_o, bhe_no, mio_o, dtr_o, den_no, rd_no, wr_no;

  bus_cycle_seq #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_write_i(req_write_i),
    .req_io_i(req_io_i), .req_word_i(req_word_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .done_o(done_o), .rdata_o(rdata_o), .ready_i(ready_i),
    .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .a_hi_o(a_hi_o), .ale_o(ale_o),
    .bhe_no(bhe_no), .mio_o(mio_o), .dtr_o(dtr_o), .den_no(den_no), .rd_no(rd_no),
    .wr_no(wr_no)
  );

  // byte-wide memory model on a 16-bit bus
  logic [7:0]    mem8 [0:127];
  logic [AW-1:0] lat_addr = '0;
  logic          lat_bhe = 1'b1;

  always @(negedge clk) if (ale_o) begin
    lat_addr <= {a_hi_o, ad_o};
    lat_bhe  <= bhe_no;
  end

  assign ad_i = !rd_no ? {mem8[{lat_addr[6:1], 1'b1}], mem8[{lat_addr[6:1], 1'b0}]} : 16'h0;

  always @(posedge wr_no) if (rst_ni) begin
    if (!lat_addr[0]) mem8[{lat_addr[6:1], 1'b0}] = ad_o[7:0];
    if (!lat_bhe)     mem8[{lat_addr[6:1], 1'b1}] = ad_o[15:8];
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  // One transfer; dly<0 keeps ready high, else ready low until clock dly of the cycle
  task automatic run_cycle(input bit wr, input bit io, input bit word,
                           input logic [AW-1:0] addr, input logic [15:0] wd,
                           input int dly, output logic [15:0] rd);
    bit   split = word & addr[0];
    int   ncyc  = split ? 2 : 1;
    int   cyc = -1, idx = 0, guard = 0, exp_len;
    bit   fin = 0, strobe_ok = 1, want_ale = 0, mid_ok;
    logic [AW-1:0] ea;
    logic [7:0]    b;
    rd = '0;
    ready_i = (dly < 0);
    repeat (3) @(negedge clk);
    req_write_i = wr; req_io_i = io; req_word_i = word;
    req_addr_i = addr; req_wdata_i = wd; req_i = 1'b1;
    while (!fin && guard < 80) begin
      @(negedge clk);
      guard++;
      req_i = 1'b0;
      if (want_ale) begin
        chk(ale_o == 1'b1, "R9", "second T1 right after first T4", ale_o, 1);
        want_ale = 0;
      end
      if (ale_o) begin
        cyc++; idx = 0; strobe_ok = 1;
        ea = addr + AW'(cyc);
        chk(ad_oe_o && ad_o == ea[15:0] && a_hi_o == ea[19:16] && mio_o == !io &&
            dtr_o == wr && rd_no && wr_no && den_no,
            "R3", "T1 address/controls", {a_hi_o, ad_o}, ea);
        chk(bhe_no == !(ea[0] || (word && !split)), "R8", "bhe_no in T1", bhe_no,
            !(ea[0] || (word && !split)));
        if (dly == 0 && cyc == 0) ready_i = 1'b1;
      end else if (cyc >= 0) begin
        idx++;
        if (!den_no) begin
          b = (split && cyc == 1) ? wd[15:8] : wd[7:0];
          if (wr)
            mid_ok = !wr_no && rd_no && ad_oe_o &&
                     ((word && !split) ? ad_o == wd : (ea[0] ? ad_o[15:8] == b : ad_o[7:0] == b));
          else
            mid_ok = !rd_no && wr_no && !ad_oe_o;
          if (!mid_ok || done_o) strobe_ok = 0;
        end else begin
          chk(strobe_ok, "R4", "strobes/data T2..last wait", strobe_ok, 1);
          chk(rd_no && wr_no && den_no && (ad_oe_o == wr), "R6", "T4 release, write hold",
              {rd_no, wr_no, den_no, ad_oe_o}, {3'b111, wr});
          exp_len = 4 + ((cyc == 0 && dly > 0) ? dly : 0);
          chk(idx + 1 == exp_len, (dly > 0 && cyc == 0) ? "R5" : "R2", "cycle length",
              idx + 1, exp_len);
          if (cyc == ncyc - 1) begin
            chk(done_o, "R6", "done in final T4", done_o, 1);
            rd = rdata_o;
            fin = 1;
          end else begin
            chk(!done_o, "R9", "no done after first half", done_o, 0);
            want_ale = 1;
          end
        end
        if (dly > 0 && cyc == 0 && idx == dly) ready_i = 1'b1;
      end
    end
    if (!fin) chk(0, "R2", "cycle did not finish", guard, 0);
    @(negedge clk);
    chk(!done_o && !ale_o, "R6", "done lasts one clock", done_o, 0);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk(!ale_o && rd_no && wr_no && den_no && !ad_oe_o && bhe_no && !done_o, "R1",
        "outputs in reset", {ale_o, rd_no, wr_no, den_no, ad_oe_o, bhe_no, done_o}, 7'b0111010);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!ale_o && rd_no && wr_no && den_no && !ad_oe_o && !done_o, "R1",
        "outputs after reset", {ale_o, rd_no, wr_no, den_no, ad_oe_o}, 5'b01110);
  endtask

  task automatic t_idle();
    bit ok = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (ale_o || !rd_no || !wr_no || ad_oe_o) ok = 0;
    end
    chk(ok, "R10", "quiet while idle", ok, 1);
  endtask

  task automatic t_word_even();
    logic [15:0] r;
    run_cycle(1, 0, 1, 20'h5_0010, 16'hA55A, -1, r);
    chk(mem8[16] == 8'h5A && mem8[17] == 8'hA5, "R8", "even word write both lanes",
        {mem8[17], mem8[16]}, 16'hA55A);
    run_cycle(0, 0, 1, 20'h5_0010, 16'h0, -1, r);
    chk(r == 16'hA55A, "R7", "even word read", r, 16'hA55A);
  endtask

  task automatic t_byte_lanes();
    logic [15:0] r;
    run_cycle(1, 0, 0, 20'h2_0020, 16'hEE11, -1, r);
    chk(mem8[32] == 8'h11 && mem8[33] == 8'h00, "R8", "even byte write low lane only",
        {mem8[33], mem8[32]}, 16'h0011);
    run_cycle(1, 0, 0, 20'h2_0023, 16'hDD99, -1, r);
    chk(mem8[35] == 8'h99 && mem8[34] == 8'h00, "R8", "odd byte write high lane only",
        {mem8[35], mem8[34]}, 16'h9900);
    run_cycle(0, 0, 0, 20'h2_0023, 16'h0, -1, r);
    chk(r == 16'h0099, "R8", "odd byte read", r, 16'h0099);
    run_cycle(0, 0, 0, 20'h2_0020, 16'h0, -1, r);
    chk(r == 16'h0011, "R7", "even byte read", r, 16'h0011);
  endtask

  task automatic t_wait_states();
    logic [15:0] r;
    run_cycle(1, 0, 1, 20'h0_0040, 16'h1234, 0, r);
    run_cycle(1, 0, 1, 20'h0_0042, 16'h5678, 1, r);
    run_cycle(1, 0, 1, 20'h0_0044, 16'h9ABC, 3, r);
    chk(mem8[68] == 8'hBC && mem8[69] == 8'h9A, "R5", "write held across waits",
        {mem8[69], mem8[68]}, 16'h9ABC);
    run_cycle(0, 0, 1, 20'h0_0042, 16'h0, 2, r);
    chk(r == 16'h5678, "R5", "read after two waits", r, 16'h5678);
  endtask

  task automatic t_io_space();
    logic [15:0] r;
    run_cycle(1, 1, 1, 20'h0_0050, 16'hC0DE, -1, r);
    run_cycle(0, 1, 1, 20'h0_0050, 16'h0, 1, r);
    chk(r == 16'hC0DE, "R3", "I/O space round trip", r, 16'hC0DE);
  endtask

  task automatic t_odd_word();
    logic [15:0] r;
    run_cycle(1, 0, 1, 20'h1_0031, 16'hBEEF, -1, r);
    chk(mem8[49] == 8'hEF && mem8[50] == 8'hBE && mem8[48] == 8'h00 && mem8[51] == 8'h00,
        "R9", "odd word write split", {mem8[50], mem8[49]}, 16'hBEEF);
    run_cycle(0, 0, 1, 20'h1_0031, 16'h0, 2, r);
    chk(r == 16'hBEEF, "R9", "odd word read split", r, 16'hBEEF);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem8[i] = 8'h00;
    t_reset();
    t_idle();
    t_word_even();
    t_byte_lanes();
    t_wait_states();
    t_io_space();
    t_odd_word();
    t_idle();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule